// File: doc/BRIEF.md
# Delayed Byte Response Transmitter

This block sends a stored response to a synchronous serial transmit port, one byte each time the port raises its transmit-ready strobe. After a start pulse, it first sends a programmable number of idle zero bytes as a lead-in delay. It then reads the response bytes from a small external buffer in address order and sends them. After the response it sends zero padding and stops by itself once the post-delay slot index exceeds the response length by more than the tail constant. With the defaults that is five slots after the last response byte.

A controller loads the response into the buffer and sets the delay and length inputs. It then pulses start and waits for the one-cycle done flag. An abort input can end the transmission at any point. A receive path running in parallel is drained so it never stalls. Its bytes are acknowledged and thrown away. The serial shifter and any carrier modulation sit outside this block.

Top module: `dlyresp_tx`

## Requirements
- R1: Out of reset, tx_data_o is 0x00 and tx_vld_o and done_o are 0. While a transmission is active, each tx_rdy_i strobe produces exactly one tx_vld_o pulse in the following cycle, with the byte on tx_data_o. Strobes while idle produce no pulse.
- R2: The first D strobes after start each send 0x00, where D is delay_i latched at start. They do not advance the response index.
- R3: Each post-delay strobe with index k below the latched length L sends the buffer byte at address k. buf_addr_o carries k during that slot, and k starts at 0 and rises by one per post-delay strobe.
- R4: Post-delay strobes with k of L or more send 0x00. The transmission ends on post-delay strobe number L+TAIL_XS+1. done_o rises in the same cycle as that strobe's tx_vld_o pulse.
- R5: abort_i high while active ends the transmission. done_o pulses in the next cycle, and a strobe in the same cycle as the abort sends no byte. abort_i while idle has no effect.
- R6: done_o is never high for two cycles in a row.
- R7: A start pulse while active is ignored. Delay and length are latched only when a start is accepted, so later changes to delay_i or len_i do not alter the running transmission.
- R8: With a latched length of 0, the block sends D delay bytes followed by TAIL_XS+1 zero bytes, and then ends.
- R9: In the default drain variant, rx_ack_o equals rx_vld_i in every cycle and in every state.
- R10: When a start is accepted, tx_data_o is reset to 0x00 in the next cycle, before the first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| delay_i | input | DLY_W | Number of lead-in zero bytes |
| len_i | input | LEN_W | Response length in bytes |
| buf_addr_o | output | LEN_W | Read address to the response buffer |
| buf_data_i | input | DATA_W | Buffer byte at buf_addr_o, same cycle |
| tx_rdy_i | input | 1 | Transmit-ready strobe, one byte slot |
| tx_data_o | output | DATA_W | Transmit byte |
| tx_vld_o | output | 1 | One-cycle byte-valid pulse |
| abort_i | input | 1 | Ends an active transmission |
| done_o | output | 1 | One-cycle end-of-transmission pulse |
| rx_vld_i | input | 1 | Received byte waiting |
| rx_ack_o | output | 1 | Received byte taken and discarded |

## Verification
Two functions can fall in the same cycle: the last transmit slot, which ends the run on its own, and an abort. The bench provokes this by counting strobes in a continuous run and raising abort_i together with the strobe that would be final. The reference model then expects a single done pulse with no byte pulse. Abort is also raised together with the first delay strobe, and a start is raised mid-run, so that priority and the ignore rule can be judged cycle by cycle against the model.

// File: rtl/dlyresp_pkg.sv
package dlyresp_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DELAY = 2'd1,
      PH_BODY  = 2'd2
   } phase_e;

   function automatic int unsigned idx_width(input int unsigned len_w, input int unsigned tail);
      return $clog2((2 ** len_w) + tail + 2);
   endfunction

endpackage

// File: rtl/dlyresp_seq.sv
module dlyresp_seq
   import dlyresp_pkg::*;
#(
   parameter int unsigned LEN_W   = 5,
   parameter int unsigned DLY_W   = 8,
   parameter int unsigned TAIL_XS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [DLY_W-1:0] delay_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             tx_rdy_i,
   input  logic             abort_i,
   output logic             start_acc_o,
   output logic             slot_o,
   output logic             sel_o,
   output logic             final_o,
   output logic             abort_hit_o,
   output logic [LEN_W-1:0] buf_addr_o
);
   localparam int unsigned IDX_W = idx_width(LEN_W, TAIL_XS);

   phase_e             phase_q;
   logic [DLY_W-1:0]   dly_q, dcnt_q, dcnt_nxt;
   logic [LEN_W-1:0]   len_q;
   logic [IDX_W-1:0]   idx_q, idx_nxt, len_ext, stop_lim;
   logic               active;

   always_comb begin
      active      = (phase_q != PH_IDLE);
      start_acc_o = !active && start_i;
      abort_hit_o = active && abort_i;
      slot_o      = active && tx_rdy_i && !abort_i;
      len_ext     = IDX_W'(len_q);
      stop_lim    = len_ext + IDX_W'(TAIL_XS);
      idx_nxt     = idx_q + 1'b1;
      dcnt_nxt    = dcnt_q + 1'b1;
      sel_o       = (phase_q == PH_BODY) && (idx_q < len_ext);
      final_o     = slot_o && (phase_q == PH_BODY) && (idx_nxt > stop_lim);
      buf_addr_o  = idx_q[LEN_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         dly_q   <= '0;
         dcnt_q  <= '0;
         len_q   <= '0;
         idx_q   <= '0;
      end else if (start_acc_o) begin
         dly_q   <= delay_i;
         len_q   <= len_i;
         dcnt_q  <= '0;
         idx_q   <= '0;
         phase_q <= (delay_i == '0) ? PH_BODY : PH_DELAY;
      end else if (abort_hit_o) begin
         phase_q <= PH_IDLE;
      end else if (slot_o) begin
         case (phase_q)
            PH_DELAY: begin
               dcnt_q <= dcnt_nxt;
               if (dcnt_nxt == dly_q) phase_q <= PH_BODY;
            end
            PH_BODY: begin
               idx_q <= idx_nxt;
               if (final_o) phase_q <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   // R2: the lead-in counter never reaches the latched delay while in the delay phase
   assert_dcnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DELAY) |-> (dcnt_q < dly_q));

   // R4: the index never passes the stop limit while sending
   assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_BODY) |-> (idx_q <= stop_lim));

   // R7: a start during a run leaves the latched settings untouched
   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && start_i) |=> (len_q == $past(len_q) && dly_q == $past(dly_q)));

   // R5: abort while active returns to idle
   assert_abort_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && abort_i) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/dlyresp_txreg.sv
module dlyresp_txreg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_acc_i,
   input  logic              slot_i,
   input  logic              sel_i,
   input  logic              final_i,
   input  logic              abort_hit_i,
   input  logic [DATA_W-1:0] buf_data_i,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              tx_vld_o,
   output logic              done_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_data_o <= '0;
         tx_vld_o  <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         tx_vld_o <= slot_i;
         done_o   <= final_i || abort_hit_i;
         if (start_acc_i)
            tx_data_o <= '0;
         else if (slot_i)
            tx_data_o <= sel_i ? buf_data_i : '0;
      end
   end

   // R1: a byte pulse only follows a taken slot
   assert_vld_needs_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_vld_o |-> $past(slot_i));

   // R6: done lasts one cycle
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4: slots outside the response carry zero
   assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_i && !sel_i) |=> (tx_data_o == '0));

   // R10: accepted start clears the holding byte
   assert_preload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_acc_i |=> (tx_data_o == '0));

endmodule

// File: rtl/dlyresp_tx.sv
module dlyresp_tx #(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned LEN_W        = 5,
   parameter int unsigned DLY_W        = 8,
   parameter int unsigned TAIL_XS      = 4,
   parameter bit          DRAIN_ALWAYS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DLY_W-1:0]  delay_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic [LEN_W-1:0]  buf_addr_o,
   input  logic [DATA_W-1:0] buf_data_i,
   input  logic              tx_rdy_i,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              tx_vld_o,
   input  logic              abort_i,
   output logic              done_o,
   input  logic              rx_vld_i,
   output logic              rx_ack_o
);

   generate
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
         $error("DATA_W out of range");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W out of range");
      end
      if (DLY_W < 1 || DLY_W > 32) begin : g_bad_dly
         $error("DLY_W out of range");
      end
      if (TAIL_XS > 1024) begin : g_bad_tail
         $error("TAIL_XS out of range");
      end
   endgenerate

   logic start_acc, slot, sel, final_slot, abort_hit;

   dlyresp_seq #(
      .LEN_W  (LEN_W),
      .DLY_W  (DLY_W),
      .TAIL_XS(TAIL_XS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .delay_i    (delay_i),
      .len_i      (len_i),
      .tx_rdy_i   (tx_rdy_i),
      .abort_i    (abort_i),
      .start_acc_o(start_acc),
      .slot_o     (slot),
      .sel_o      (sel),
      .final_o    (final_slot),
      .abort_hit_o(abort_hit),
      .buf_addr_o (buf_addr_o)
   );

   dlyresp_txreg #(
      .DATA_W(DATA_W)
   ) u_txreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_acc_i(start_acc),
      .slot_i     (slot),
      .sel_i      (sel),
      .final_i    (final_slot),
      .abort_hit_i(abort_hit),
      .buf_data_i (buf_data_i),
      .tx_data_o  (tx_data_o),
      .tx_vld_o   (tx_vld_o),
      .done_o     (done_o)
   );

   generate
      if (DRAIN_ALWAYS) begin : g_drain_comb
         assign rx_ack_o = rx_vld_i;
      end else begin : g_drain_reg
         logic ack_q;
         always_ff @(posedge clk) begin
            if (!rst_n) ack_q <= 1'b0;
            else        ack_q <= rx_vld_i && !ack_q;
         end
         assign rx_ack_o = ack_q;
         // R9: registered drain never acknowledges twice in a row
         assert_drain_pace_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rx_ack_o |=> !rx_ack_o);
      end
   endgenerate

endmodule

// File: tb/dlyresp_tx_tb.sv
`timescale 1ns/1ps
module dlyresp_tx_tb;
   localparam int DATA_W = 8, LEN_W = 5, DLY_W = 8, TAIL_XS = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [DLY_W-1:0]  delay_i = '0;
   logic [LEN_W-1:0]  len_i = '0;
   logic [LEN_W-1:0]  buf_addr_o;
   logic [DATA_W-1:0] buf_data_i;
   logic              tx_rdy_i = 1'b0;
   logic [DATA_W-1:0] tx_data_o;
   logic              tx_vld_o;
   logic              abort_i = 1'b0;
   logic              done_o;
   logic              rx_vld_i = 1'b0;
   logic              rx_ack_o;

   always #2.5 clk = ~clk;

   logic [DATA_W-1:0] mem [0:(2**LEN_W)-1];
   assign buf_data_i = mem[buf_addr_o];

   dlyresp_tx #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DLY_W(DLY_W), .TAIL_XS(TAIL_XS)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .delay_i(delay_i), .len_i(len_i),
      .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i), .tx_rdy_i(tx_rdy_i),
      .tx_data_o(tx_data_o), .tx_vld_o(tx_vld_o), .abort_i(abort_i), .done_o(done_o),
      .rx_vld_i(rx_vld_i), .rx_ack_o(rx_ack_o));

   int    n_vec = 0, n_bad = 0, cyc = 0;
   string cur_req = "R1";

   // behavioural reference
   bit m_busy = 0;
   int m_dly = 0, m_len = 0, m_d = 0, m_i = 0;
   int exp_tx = 0;
   bit exp_vld = 0, exp_done = 0;

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", req, what, got, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      exp_vld  = 0;
      exp_done = 0;
      if (!rst_n) begin
         m_busy = 0; exp_tx = 0;
      end else if (!m_busy) begin
         if (start_i) begin
            m_busy = 1; m_dly = int'(delay_i); m_len = int'(len_i);
            m_d = 0; m_i = 0; exp_tx = 0;
         end
      end else if (abort_i) begin
         m_busy = 0; exp_done = 1;
      end else if (tx_rdy_i) begin
         exp_vld = 1;
         if (m_d < m_dly) begin
            exp_tx = 0; m_d++;
         end else begin
            exp_tx = (m_i < m_len) ? int'(mem[m_i]) : 0;
            m_i++;
            if (m_i > m_len + TAIL_XS) begin
               m_busy = 0; exp_done = 1;
            end
         end
      end
      #1;
      if (rst_n) begin
         chk(cur_req, "tx_vld_o (R1)", int'(tx_vld_o), int'(exp_vld));
         chk(cur_req, "tx_data_o (R3/R4)", int'(tx_data_o), exp_tx);
         chk(cur_req, "done_o (R4/R5/R6)", int'(done_o), int'(exp_done));
         chk("R9", "rx_ack_o", int'(rx_ack_o), int'(rx_vld_i));
         if (m_busy && m_d >= m_dly && m_i < m_len)
            chk("R3", "buf_addr_o", int'(buf_addr_o), m_i);
      end
   end

   // receive traffic running in the background
   always @(negedge clk) rx_vld_i <= (cyc % 3 != 1);

   task automatic run(input int dly, input int len, input int gap, input int abort_at,
                      input int restart_at, input string req);
      int n;
      cur_req = req;
      @(negedge clk);
      start_i = 1; delay_i = DLY_W'(dly); len_i = LEN_W'(len);
      @(negedge clk);
      start_i = 0;
      n = 0;
      while (m_busy && n < 300) begin
         for (int g = 0; g < gap; g++) begin
            tx_rdy_i = (g == 0 && gap > 1) ? 1'b0 : 1'b0;
            @(negedge clk);
         end
         tx_rdy_i = 1;
         abort_i  = (n == abort_at);
         if (n == restart_at) begin
            start_i = 1; delay_i = DLY_W'(dly + 7); len_i = LEN_W'(len + 3);
         end
         @(negedge clk);
         tx_rdy_i = 0; abort_i = 0; start_i = 0;
         delay_i = DLY_W'(dly + 1); len_i = LEN_W'(len + 1);
         n++;
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < 2 ** LEN_W; k++) mem[k] = DATA_W'(k * 37 + 11);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "reset tx_data_o", int'(tx_data_o), 0);
      chk("R1", "reset tx_vld_o", int'(tx_vld_o), 0);
      chk("R1", "reset done_o", int'(done_o), 0);
      rst_n = 1;
      // R1: strobes while idle do nothing
      cur_req = "R1";
      repeat (2) begin
         @(negedge clk); tx_rdy_i = 1; abort_i = 1;
         @(negedge clk); tx_rdy_i = 0; abort_i = 0;
      end
      run(3, 4, 0, -1, -1, "R2");        // R2, R3, R4 back-to-back strobes
      run(2, 6, 2, -1, -1, "R3");        // R1, R3 sparse strobes
      run(0, 0, 0, -1, -1, "R8");        // R8 empty response, no delay
      run(4, 0, 1, -1, -1, "R8");        // R8 empty response after delay
      run(1, 5, 0, -1, 3, "R7");         // R7 start mid-run ignored
      run(2, 9, 0, 6, -1, "R5");         // R5 abort mid-response
      run(1, 3, 0, -1, -1, "R10");       // R10 preload after aborted run
      run(4, 3, 0, 0, -1, "R5");         // R5 abort with first delay strobe
      run(1, 2, 0, 7, -1, "R6");         // R5/R6 abort together with the final strobe
      run(0, 31, 0, -1, -1, "R4");       // R4 full-length response
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule